// File: doc/BRIEF.md
# Configuration Request Responder

This block sits on the slave side of a fixed-size serial motion bus. It takes one decoded configuration request and answers it: a 12-bit register address, a 3-bit command, four 16-bit data words and a flag that says whether the frame arrived with a good CRC. It looks the address up in an external register dictionary and forms the reply: a header (address and reply command) and four reply data words. It also drives the dictionary's read and write strobes.

The dictionary answers in the same cycle. Given an address, it returns whether the register exists, its current value, its size in bytes, its data type, its cyclic class and its access rights. The reply appears one clock after the request as a single-cycle pulse. CRC generation, framing, fragmentation of long strings and the physical link are handled elsewhere.

Top module: `cfg_responder`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next clock. `rsp_valid` is low in every other cycle, and all reply outputs are zero after reset.
- R2: Request commands are 3'b000 get-info, 3'b001 read, 3'b010 write and 3'b111 idle. Any other code gives reply command 3'b101 (read error) with error code 0x08010030.
- R3: A read of an existing register whose access code has bit 1 set pulses `dict_rd_en` in the request cycle. It replies 3'b011 (ACK), echoes the address and returns the 64-bit value with the least significant word in `rsp_data[15:0]`.
- R4: A write to an existing register whose access code has bit 2 set pulses `dict_wr_en` in the request cycle with `dict_wdata` equal to `req_data`. It replies ACK with the address echoed and all data words zero.
- R5: A write to a register without write rights gives 3'b110 (write error). A read of a register without read rights gives 3'b101. Both carry 0x06010000 and neither touches the dictionary. Access codes are 3 (read only), 5 (write only) and 7 (read/write).
- R6: An address is absent when `dict_found` is low or address bit 11 is set. Such a request carries 0x06020000: a write gets 3'b110, a read or get-info gets 3'b101, and no strobe fires.
- R7: A get-info of an existing register replies ACK with size in bits 7..0, data type in 13..8, cyclic class in 15..14 and access code in 18..16, and all upper bits zero. It makes no dictionary access.
- R8: A request flagged with a bad CRC carries 0x08010040. A write gets 3'b110 and every other command gets 3'b101. No strobe fires.
- R9: An idle request with good CRC replies 3'b111 with address and data zero and makes no dictionary access.
- R10: Every error reply echoes the request address, holds the 32-bit code in data words 0 and 1 (low word first) and sets words 2 and 3 to zero.
- R11: A read or write of an existing register whose access code is not 3, 5 or 7 carries the general error 0x08000000 in the direction of the request, with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded request present this cycle |
| req_addr | input | 12 | Request register address |
| req_cmd | input | 3 | Request command code |
| req_data | input | 64 | Request data words, word 0 in bits 15:0 |
| req_crc_ok | input | 1 | Request frame passed its CRC check |
| dict_addr | output | 12 | Dictionary lookup address |
| dict_rd_en | output | 1 | Dictionary read strobe |
| dict_wr_en | output | 1 | Dictionary write strobe |
| dict_wdata | output | 64 | Dictionary write value |
| dict_rdata | input | 64 | Dictionary register value |
| dict_found | input | 1 | Register exists in the dictionary |
| dict_size | input | 8 | Register size in bytes |
| dict_type | input | 6 | Register data type code |
| dict_cyc | input | 2 | Register cyclic class code |
| dict_acc | input | 3 | Register access code |
| rsp_valid | output | 1 | Reply present this cycle |
| rsp_addr | output | 12 | Reply header address |
| rsp_cmd | output | 3 | Reply command code |
| rsp_data | output | 64 | Reply data words, word 0 in bits 15:0 |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 16-bit words and four data words. With these values the reserved top address bit can be exercised, and a full 64-bit register value travels through the reply. The bench's dictionary model holds read/write, read-only, write-only and malformed access codes, so every error branch is reachable in both request directions. Random addresses with bit 11 set alias real registers, which checks that the reserved bit is honoured rather than left to the dictionary.

// File: rtl/cfg_responder.sv
module cfg_responder #(
  parameter int ADDR_W  = 12,
  parameter int WORD_W  = 16,
  parameter int N_WORDS = 4,
  localparam int DATA_W = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_cmd,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_crc_ok,
  output logic [ADDR_W-1:0] dict_addr,
  output logic              dict_rd_en,
  output logic              dict_wr_en,
  output logic [DATA_W-1:0] dict_wdata,
  input  logic [DATA_W-1:0] dict_rdata,
  input  logic              dict_found,
  input  logic [7:0]        dict_size,
  input  logic [5:0]        dict_type,
  input  logic [1:0]        dict_cyc,
  input  logic [2:0]        dict_acc,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [2:0]        rsp_cmd,
  output logic [DATA_W-1:0] rsp_data
);
  localparam logic [2:0] C_INFO = 3'b000, C_READ = 3'b001, C_WRITE = 3'b010, C_IDLE = 3'b111;
  localparam logic [2:0] R_ACK = 3'b011, R_ERD = 3'b101, R_EWR = 3'b110;
  localparam logic [31:0] E_UNSUP = 32'h0601_0000, E_NOREG = 32'h0602_0000,
                          E_GEN = 32'h0800_0000, E_CRC = 32'h0801_0040, E_BADCMD = 32'h0801_0030;

  logic known, exists, acc_ok, can_rd, can_wr, go, err;
  logic [31:0] code;
  logic [2:0] nxt_cmd;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_data;

  assign known  = req_cmd inside {C_INFO, C_READ, C_WRITE, C_IDLE};
  assign exists = dict_found && !req_addr[ADDR_W-1];
  assign acc_ok = dict_acc inside {3'd3, 3'd5, 3'd7};
  assign can_rd = dict_acc[1];
  assign can_wr = dict_acc[2];
  assign go     = req_valid && req_crc_ok && exists && acc_ok;

  assign dict_addr  = req_addr;
  assign dict_wdata = req_data;
  assign dict_rd_en = go && req_cmd == C_READ && can_rd;
  assign dict_wr_en = go && req_cmd == C_WRITE && can_wr;

  always_comb begin
    err      = 1'b0;
    code     = '0;
    nxt_cmd  = R_ACK;
    nxt_addr = req_addr;
    nxt_data = '0;
    if (!req_crc_ok) begin
      err  = 1'b1;
      code = E_CRC;
    end else if (!known) begin
      err  = 1'b1;
      code = E_BADCMD;
    end else if (req_cmd == C_IDLE) begin
      nxt_cmd  = C_IDLE;
      nxt_addr = '0;
    end else if (!exists) begin
      err  = 1'b1;
      code = E_NOREG;
    end else if (req_cmd == C_INFO) begin
      nxt_data = DATA_W'({dict_acc, dict_cyc, dict_type, dict_size});
    end else if (!acc_ok) begin
      err  = 1'b1;
      code = E_GEN;
    end else if (req_cmd == C_READ) begin
      if (can_rd) nxt_data = dict_rdata;
      else begin
        err  = 1'b1;
        code = E_UNSUP;
      end
    end else if (!can_wr) begin
      err  = 1'b1;
      code = E_UNSUP;
    end
    if (err) begin
      nxt_cmd  = (req_cmd == C_WRITE) ? R_EWR : R_ERD;
      nxt_data = DATA_W'(code);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_cmd   <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= nxt_addr;
        rsp_cmd  <= nxt_cmd;
        rsp_data <= nxt_data;
      end
    end
  end
endmodule

// File: rtl/cfg_responder_chk.sv
module cfg_responder_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        req_cmd,
  input logic              req_crc_ok,
  input logic              dict_rd_en,
  input logic              dict_wr_en,
  input logic [DATA_W-1:0] dict_rdata,
  input logic              rsp_valid,
  input logic [2:0]        rsp_cmd,
  input logic [DATA_W-1:0] rsp_data
);
  p_reply_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_read_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dict_rd_en |=> (rsp_cmd == 3'b011 && rsp_data == $past(dict_rdata)));
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dict_rd_en && dict_wr_en));
  p_write_needs_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dict_wr_en |-> (req_valid && req_cmd == 3'b010 && req_crc_ok));
  p_reserved_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1]) |-> (!dict_rd_en && !dict_wr_en));
  p_crc_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_crc_ok) |-> (!dict_rd_en && !dict_wr_en));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 3'b111) |-> (!dict_rd_en && !dict_wr_en));
  p_err_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_cmd == 3'b101 || rsp_cmd == 3'b110)) |-> (rsp_data[DATA_W-1:32] == '0));
endmodule

bind cfg_responder cfg_responder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_cmd(req_cmd), .req_crc_ok(req_crc_ok), .dict_rd_en(dict_rd_en),
  .dict_wr_en(dict_wr_en), .dict_rdata(dict_rdata), .rsp_valid(rsp_valid),
  .rsp_cmd(rsp_cmd), .rsp_data(rsp_data));

// File: tb/test_cfg_responder.sv
`timescale 1ns/1ps
module test_cfg_responder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_crc_ok = 1'b1;
  logic [11:0] req_addr = '0;
  logic [2:0] req_cmd = '0;
  logic [63:0] req_data = '0;
  logic [11:0] dict_addr;
  logic dict_rd_en, dict_wr_en, dict_found;
  logic [63:0] dict_wdata, dict_rdata;
  logic [7:0] dict_size;
  logic [5:0] dict_type;
  logic [1:0] dict_cyc;
  logic [2:0] dict_acc;
  logic rsp_valid;
  logic [11:0] rsp_addr;
  logic [2:0] rsp_cmd;
  logic [63:0] rsp_data;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [10:0] b_key [8];
  logic [63:0] b_val [8];
  logic [7:0]  b_size [8];
  logic [5:0]  b_type [8];
  logic [1:0]  b_cyc [8];
  logic [2:0]  b_acc [8];

  always #2.5 clk = ~clk;

  cfg_responder i_cfg_responder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_data(req_data), .req_crc_ok(req_crc_ok),
    .dict_addr(dict_addr), .dict_rd_en(dict_rd_en), .dict_wr_en(dict_wr_en),
    .dict_wdata(dict_wdata), .dict_rdata(dict_rdata), .dict_found(dict_found),
    .dict_size(dict_size), .dict_type(dict_type), .dict_cyc(dict_cyc),
    .dict_acc(dict_acc), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_cmd(rsp_cmd), .rsp_data(rsp_data));

  always_comb begin
    dict_found = 1'b0; dict_rdata = '0; dict_size = '0;
    dict_type = '0; dict_cyc = '0; dict_acc = '0;
    for (int i = 0; i < 8; i++)
      if (b_key[i] == dict_addr[10:0]) begin
        dict_found = 1'b1; dict_rdata = b_val[i]; dict_size = b_size[i];
        dict_type = b_type[i]; dict_cyc = b_cyc[i]; dict_acc = b_acc[i];
      end
  end

  always @(posedge clk)
    if (dict_wr_en)
      for (int i = 0; i < 8; i++)
        if (b_key[i] == dict_addr[10:0]) b_val[i] <= dict_wdata;

  function automatic int lookup(input logic [11:0] a);
    lookup = -1;
    if (!a[11])
      for (int i = 0; i < 8; i++) if (b_key[i] == a[10:0]) lookup = i;
  endfunction

  function automatic void model(input logic [11:0] a, input logic [2:0] c,
      input bit ok, output logic [2:0] ec, output logic [11:0] ea,
      output logic [63:0] ed, output bit erd, output bit ewr,
      output bit iserr, output string tag);
    int k;
    logic [31:0] code;
    k = lookup(a);
    ec = 3'b011; ea = a; ed = '0; erd = 0; ewr = 0; iserr = 0; code = '0;
    if (!ok) begin iserr = 1; code = 32'h08010040; tag = "R8"; end
    else if (!(c inside {3'b000, 3'b001, 3'b010, 3'b111})) begin
      iserr = 1; code = 32'h08010030; tag = "R2"; end
    else if (c == 3'b111) begin ec = 3'b111; ea = '0; tag = "R9"; end
    else if (k < 0) begin iserr = 1; code = 32'h06020000; tag = "R6"; end
    else if (c == 3'b000) begin
      ed = {45'd0, b_acc[k], b_cyc[k], b_type[k], b_size[k]}; tag = "R7"; end
    else if (!(b_acc[k] inside {3'd3, 3'd5, 3'd7})) begin
      iserr = 1; code = 32'h08000000; tag = "R11"; end
    else if (c == 3'b001) begin
      if (b_acc[k][1]) begin ed = b_val[k]; erd = 1; tag = "R3"; end
      else begin iserr = 1; code = 32'h06010000; tag = "R5"; end
    end else begin
      if (b_acc[k][2]) begin ewr = 1; tag = "R4"; end
      else begin iserr = 1; code = 32'h06010000; tag = "R5"; end
    end
    if (iserr) begin
      ec = (c == 3'b010) ? 3'b110 : 3'b101;
      ed = {32'd0, code};
    end
  endfunction

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [11:0] a, input logic [2:0] c,
                        input logic [63:0] d, input bit ok);
    logic [2:0] ec; logic [11:0] ea; logic [63:0] ed;
    bit erd, ewr, iserr; string tag;
    model(a, c, ok, ec, ea, ed, erd, ewr, iserr, tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmd = c; req_data = d; req_crc_ok = ok;
    #1;
    chk(dict_rd_en == erd, tag, "rd strobe", 64'(dict_rd_en), 64'(erd));
    chk(dict_wr_en == ewr, tag, "wr strobe", 64'(dict_wr_en), 64'(ewr));
    if (ewr) chk(dict_wdata == d, "R4", "wdata", dict_wdata, d);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R1", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_cmd == ec, tag, "rsp_cmd", 64'(rsp_cmd), 64'(ec));
    chk(rsp_addr == ea, iserr ? "R10" : tag, "rsp_addr", 64'(rsp_addr), 64'(ea));
    chk(rsp_data == ed, iserr ? "R10" : tag, "rsp_data", rsp_data, ed);
  endtask

  initial begin
    logic [10:0] keys [8] = '{11'h010, 11'h011, 11'h020, 11'h030, 11'h0B2, 11'h640, 11'h641, 11'h7F0};
    logic [2:0]  accs [8] = '{3'd7, 3'd3, 3'd5, 3'd0, 3'd7, 3'd7, 3'd3, 3'd5};
    void'($urandom(32'd48151623));
    for (int i = 0; i < 8; i++) begin
      b_key[i] = keys[i]; b_acc[i] = accs[i];
      b_val[i] = {$urandom, $urandom};
      b_size[i] = 8'(2 << (i % 3)); b_type[i] = 6'(i % 6); b_cyc[i] = 2'(i % 3);
    end
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && rsp_cmd == 0 && rsp_data == 0 && rsp_addr == 0,
        "R1", "reset state", {rsp_data[59:0], rsp_cmd, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1", "no request no reply", 64'(rsp_valid), 64'd0);

    do_req(12'h010, 3'b001, '0, 1);
    do_req(12'h011, 3'b001, '0, 1);
    do_req(12'h020, 3'b001, '0, 1);
    do_req(12'h011, 3'b010, 64'h1111_2222_3333_4444, 1);
    do_req(12'h010, 3'b010, 64'h1234_5678_9ABC_DEF0, 1);
    do_req(12'h010, 3'b001, '0, 1);
    chk(rsp_data[15:0] == 16'hDEF0, "R3", "low word first", 64'(rsp_data[15:0]), 64'hDEF0);
    do_req(12'h020, 3'b000, '0, 1);
    do_req(12'h0B2, 3'b000, '0, 1);
    do_req(12'h7FF, 3'b001, '0, 1);
    do_req(12'h810, 3'b001, '0, 1);
    do_req(12'h810, 3'b010, 64'hFFFF, 1);
    do_req(12'h7FF, 3'b000, '0, 1);
    do_req(12'h010, 3'b010, 64'hDEAD, 0);
    do_req(12'h010, 3'b001, '0, 0);
    do_req(12'h010, 3'b000, '0, 0);
    do_req(12'h010, 3'b111, '0, 1);
    for (int c = 3; c < 7; c++) do_req(12'h010, 3'(c), '0, 1);
    do_req(12'h030, 3'b001, '0, 1);
    do_req(12'h030, 3'b010, 64'h5, 1);
    do_req(12'h030, 3'b000, '0, 1);

    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      logic [2:0] c;
      if ($urandom % 10 < 7) a = {1'b0, b_key[$urandom % 8]};
      else if ($urandom % 2 == 0) a = {1'b1, b_key[$urandom % 8]};
      else a = 12'($urandom);
      c = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 3);
      do_req(a, c, {$urandom, $urandom}, ($urandom % 10) != 0);
    end
    @(negedge clk);
    chk(rsp_valid == 0, "R1", "reply is one cycle", 64'(rsp_valid), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule